// File: doc/BRIEF.md
# Buffered Flash Program Sequencer

This block sits behind a flash command decoder and runs the device side of the buffered program command. The decoder has already seen the two unlock writes. It raises `start_i` together with the write that carries the buffer-load opcode, and that write's address names the target sector. From then on the sequencer takes over the write bus. The next write must go to the same sector, and its data is the number of words to load minus one. Exactly that many plus one address/data writes follow, and all of them must fall in one buffer page. A final confirm write (low data byte 29h) to the same sector completes the sequence.

When the confirm is accepted, the sequencer presents one request to the array programmer for a single cycle. The request carries the page base address, a per-word valid mask and the buffered words. The sequencer then goes back to idle. Any broken rule moves it to a sticky abort state. In that state it ignores everything except a three-write clear sequence, which takes it back to idle. If the same location is loaded twice, the later data wins. The buffer holds at most 16 words, because the whole command, including the unlock and confirm writes, is limited to 21 bus writes.

Top module: `wbuf_seq`

## Requirements
- R1: After reset, `abort_o` and `prog_valid_o` are low and the sequencer is idle. Writes made while idle without `start_i` produce neither a program request nor an abort.
- R2: A write with `start_i` high, made while idle, latches the sector field of its address (bits ADDR_W-1 down to SECTOR_LSB). A following write to the same sector with data at most BUF_WORDS-1 is taken as the load count N.
- R3: A count write whose 16-bit data exceeds BUF_WORDS-1 (15 by default) moves the block to abort.
- R4: A count write or a confirm write whose sector field differs from the latched sector moves the block to abort.
- R5: After the count write, exactly N+1 writes load the buffer. Each write stores its data at the word index given by address bits log2(BUF_WORDS)-1..0 and sets the matching mask bit. The page is the address with those bits cleared, taken from the first load.
- R6: A first load address outside the latched sector, or a later load address whose page differs from the first, moves the block to abort.
- R7: When a word index is loaded more than once, the request carries the data of the last load to it.
- R8: A write whose low data byte is 29h, made to the latched sector after the last load, raises `prog_valid_o` in the cycle after that write, for exactly one cycle. In that cycle `prog_page_o`, `prog_mask_o` and `prog_words_o` show the loaded page, and the block returns to idle.
- R9: Any other write after the last load, in place of the confirm, moves the block to abort.
- R10: Abort holds `abort_o` high and ignores `start_i`. It clears only after the writes (low 11 address bits / low 8 data bits) 555h/AAh, 2AAh/55h, 555h/F0h in that order. Any other write restarts the match. Abort returns low in the cycle after the F0h write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Buffer-load command seen by the decoder, valid with wr_en_i |
| wr_en_i | input | 1 | One bus write this cycle |
| wr_addr_i | input | ADDR_W | Word address of the write |
| wr_data_i | input | DATA_W | Data of the write |
| prog_valid_o | output | 1 | One-cycle program request |
| prog_page_o | output | ADDR_W | Page base address of the request |
| prog_mask_o | output | BUF_WORDS | Loaded-word mask |
| prog_words_o | output | BUF_WORDS*DATA_W | Buffered words, index i at bits i*DATA_W and up |
| abort_o | output | 1 | Sticky abort state |

## Verification
The bench builds the block with its default parameters: a 22-bit word address, 16-bit data, a 16-word buffer and the sector field above bit 15. These values put the full 16-word load within reach, together with the boundary between count 15 and count 16. They also allow loads that stay in the sector but leave the page, and loads that leave the sector altogether. Directed sequences also cover out-of-order and repeated word indexes, wrong confirms, and a clear sequence that is broken in its last step.

// File: rtl/wbuf_pkg.sv
// Package: shared state type and command codes of the buffered program sequencer.
// Assumes command codes sit in the low data byte and unlock addresses in the low 11 address bits.
package wbuf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_LOAD,
        ST_CONFIRM,
        ST_ABORT
    } wbuf_state_e;

    localparam int          UNLK_AW     = 11;
    localparam logic [7:0]  CMD_CONFIRM = 8'h29;
    localparam logic [7:0]  CMD_UNLK1   = 8'hAA;
    localparam logic [7:0]  CMD_UNLK2   = 8'h55;
    localparam logic [7:0]  CMD_CLEAR   = 8'hF0;
    localparam logic [10:0] ADR_UNLK1   = 11'h555;
    localparam logic [10:0] ADR_UNLK2   = 11'h2AA;
endpackage

// File: rtl/wbuf_unlock_clr.sv
// Module: matches the three-write clear sequence while the sequencer is in abort.
// Assumes arm_i stays high for the whole abort period; the match restarts when it drops.
module wbuf_unlock_clr
    import wbuf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm_i,
    input  logic               wr_en_i,
    input  logic [UNLK_AW-1:0] addr_lo_i,
    input  logic [7:0]         data_lo_i,
    output logic               clr_o
);
    logic [1:0] step_q;
    logic       hit1, hit2, hit3;

    // Decode which step of the clear sequence the current write matches.
    always_comb begin
        hit1 = (addr_lo_i == ADR_UNLK1) && (data_lo_i == CMD_UNLK1);
        hit2 = (addr_lo_i == ADR_UNLK2) && (data_lo_i == CMD_UNLK2);
        hit3 = (addr_lo_i == ADR_UNLK1) && (data_lo_i == CMD_CLEAR);
    end

    // Track progress through the sequence; a mismatch restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm_i) begin
            step_q <= 2'd0;
        end else if (wr_en_i) begin
            unique case (step_q)
                2'd0:    step_q <= hit1 ? 2'd1 : 2'd0;
                2'd1:    step_q <= hit2 ? 2'd2 : (hit1 ? 2'd1 : 2'd0);
                default: step_q <= hit1 ? 2'd1 : 2'd0;
            endcase
        end
    end

    // Fire on the last write of a complete sequence.
    assign clr_o = arm_i && wr_en_i && (step_q == 2'd2) && hit3;

    p_clr_only_armed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |-> arm_i && wr_en_i && data_lo_i == CMD_CLEAR);
endmodule

// File: rtl/wbuf_store.sv
// Module: word buffer with per-word valid mask; a later write to an index overwrites it.
// Assumes clr_i and we_i are never high together.
module wbuf_store #(
    parameter int DATA_W    = 16,
    parameter int BUF_WORDS = 16,
    localparam int IDX_W    = $clog2(BUF_WORDS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr_i,
    input  logic                          we_i,
    input  logic [IDX_W-1:0]              idx_i,
    input  logic [DATA_W-1:0]             data_i,
    output logic [BUF_WORDS-1:0]          mask_o,
    output logic [BUF_WORDS*DATA_W-1:0]   words_o
);
    for (genvar i = 0; i < BUF_WORDS; i++) begin : g_word
        logic [DATA_W-1:0] word_q;
        logic              vld_q;

        // Hold one buffer word and its valid bit.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
                word_q <= '0;
                vld_q  <= 1'b0;
            end else if (we_i && idx_i == IDX_W'(i)) begin
                word_q <= data_i;
                vld_q  <= 1'b1;
            end
        end

        assign mask_o[i]                       = vld_q;
        assign words_o[i*DATA_W +: DATA_W]     = word_q;

        p_word_written_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (we_i && !clr_i && idx_i == IDX_W'(i)) |=> vld_q && word_q == $past(data_i));
    end
endmodule

// File: rtl/wbuf_seq.sv
// Module: device-side sequencer for the buffered program command.
// Takes the count, the loads and the confirm; raises a one-cycle program request or a sticky abort.
// Assumes start_i comes with the write carrying the buffer-load opcode, after the unlock pair.
module wbuf_seq
    import wbuf_pkg::*;
#(
    parameter int ADDR_W     = 22,
    parameter int DATA_W     = 16,
    parameter int BUF_WORDS  = 16,
    parameter int SECTOR_LSB = 15
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic                        wr_en_i,
    input  logic [ADDR_W-1:0]           wr_addr_i,
    input  logic [DATA_W-1:0]           wr_data_i,
    output logic                        prog_valid_o,
    output logic [ADDR_W-1:0]           prog_page_o,
    output logic [BUF_WORDS-1:0]        prog_mask_o,
    output logic [BUF_WORDS*DATA_W-1:0] prog_words_o,
    output logic                        abort_o
);
    localparam int OFF_W  = $clog2(BUF_WORDS);
    localparam int SEC_W  = ADDR_W - SECTOR_LSB;
    localparam int PAGE_W = ADDR_W - OFF_W;

    wbuf_state_e        state_q;
    logic [SEC_W-1:0]   sector_q;
    logic [PAGE_W-1:0]  page_q;
    logic [OFF_W-1:0]   left_q;
    logic [OFF_W-1:0]   cnt_q;
    logic               first_q;
    logic               prog_q;
    logic               sec_ok, page_ok, load_bad, load_we, clr_hit, start_hit;

    // Compare the current write against the latched sector and page.
    always_comb begin
        sec_ok    = wr_addr_i[ADDR_W-1:SECTOR_LSB] == sector_q;
        page_ok   = wr_addr_i[ADDR_W-1:OFF_W] == page_q;
        load_bad  = first_q ? !sec_ok : !page_ok;
        load_we   = (state_q == ST_LOAD) && wr_en_i && !load_bad;
        start_hit = (state_q == ST_IDLE) && wr_en_i && start_i;
    end

    // Main command state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            sector_q <= '0;
            page_q   <= '0;
            left_q   <= '0;
            cnt_q    <= '0;
            first_q  <= 1'b0;
            prog_q   <= 1'b0;
        end else begin
            prog_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_hit) begin
                    sector_q <= wr_addr_i[ADDR_W-1:SECTOR_LSB];
                    state_q  <= ST_COUNT;
                end
                ST_COUNT: if (wr_en_i) begin
                    if (!sec_ok || wr_data_i > DATA_W'(BUF_WORDS - 1)) begin
                        state_q <= ST_ABORT;
                    end else begin
                        left_q  <= wr_data_i[OFF_W-1:0];
                        cnt_q   <= wr_data_i[OFF_W-1:0];
                        first_q <= 1'b1;
                        state_q <= ST_LOAD;
                    end
                end
                ST_LOAD: if (wr_en_i) begin
                    if (load_bad) begin
                        state_q <= ST_ABORT;
                    end else begin
                        if (first_q) page_q <= wr_addr_i[ADDR_W-1:OFF_W];
                        first_q <= 1'b0;
                        left_q  <= left_q - 1'b1;
                        if (left_q == '0) state_q <= ST_CONFIRM;
                    end
                end
                ST_CONFIRM: if (wr_en_i) begin
                    if (sec_ok && wr_data_i[7:0] == CMD_CONFIRM) begin
                        prog_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_ABORT;
                    end
                end
                default: if (clr_hit) state_q <= ST_IDLE;
            endcase
        end
    end

    wbuf_unlock_clr u_clr (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (state_q == ST_ABORT),
        .wr_en_i   (wr_en_i),
        .addr_lo_i (wr_addr_i[UNLK_AW-1:0]),
        .data_lo_i (wr_data_i[7:0]),
        .clr_o     (clr_hit)
    );

    wbuf_store #(.DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (start_hit),
        .we_i    (load_we),
        .idx_i   (wr_addr_i[OFF_W-1:0]),
        .data_i  (wr_data_i),
        .mask_o  (prog_mask_o),
        .words_o (prog_words_o)
    );

    assign prog_valid_o = prog_q;
    assign prog_page_o  = {page_q, {OFF_W{1'b0}}};
    assign abort_o      = (state_q == ST_ABORT);

    p_prog_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        prog_valid_o |=> !prog_valid_o);
    p_prog_no_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        prog_valid_o |-> !abort_o && prog_mask_o != '0);
    p_mask_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_valid_o |-> $countones(prog_mask_o) <= int'(cnt_q) + 1);
    p_abort_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_o && !clr_hit) |=> abort_o);
    p_abort_no_prog_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !prog_valid_o);
endmodule

// File: tb/wbuf_seq_tb.sv
// Bench: directed scenarios for the buffered program sequencer, one task each.
module wbuf_seq_tb_top;
    localparam int AW = 22;
    localparam int DW = 16;
    localparam int BW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          wr_en_i = 1'b0;
    logic [AW-1:0] wr_addr_i = '0;
    logic [DW-1:0] wr_data_i = '0;
    logic          prog_valid_o;
    logic [AW-1:0] prog_page_o;
    logic [BW-1:0] prog_mask_o;
    logic [BW*DW-1:0] prog_words_o;
    logic          abort_o;

    int n_run  = 0;
    int n_fail = 0;
    logic [DW-1:0] exp_w [BW];
    logic [BW-1:0] exp_m;

    localparam logic [AW-1:0] SEC_A = 22'h0A8000;
    localparam logic [AW-1:0] SEC_B = 22'h0B0000;

    always #5 clk = ~clk;

    wbuf_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .prog_valid_o(prog_valid_o), .prog_page_o(prog_page_o),
        .prog_mask_o(prog_mask_o), .prog_words_o(prog_words_o), .abort_o(abort_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit st = 1'b0);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d; start_i = st;
        @(negedge clk);
        wr_en_i = 1'b0; start_i = 1'b0;
    endtask

    task automatic clear_exp();
        exp_m = '0;
        for (int i = 0; i < BW; i++) exp_w[i] = '0;
    endtask

    task automatic load(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr(a, d);
        exp_m[a[3:0]]   = 1'b1;
        exp_w[a[3:0]] = d;
    endtask

    // Confirm and check the one-cycle request against the expected buffer.
    task automatic confirm_check(input string req, input logic [AW-1:0] sec, input logic [AW-1:0] page);
        wr(sec, 16'h0029);
        chk(prog_valid_o === 1'b1, {req, " request raised"}, prog_valid_o, 1);
        chk(prog_page_o === page, {req, " page"}, prog_page_o, page);
        chk(prog_mask_o === exp_m, {req, " mask"}, prog_mask_o, exp_m);
        for (int i = 0; i < BW; i++)
            if (exp_m[i])
                chk(prog_words_o[i*DW +: DW] === exp_w[i], {req, " word"}, prog_words_o[i*DW +: DW], exp_w[i]);
        @(negedge clk);
        chk(prog_valid_o === 1'b0, "R8 request one cycle", prog_valid_o, 0);
        chk(abort_o === 1'b0, "R8 no abort", abort_o, 0);
    endtask

    task automatic clear_abort();
        wr(22'h000555, 16'h00AA);
        wr(22'h0002AA, 16'h0055);
        wr(22'h000555, 16'h00F0);
        chk(abort_o === 1'b0, "R10 cleared by sequence", abort_o, 0);
    endtask

    task automatic t_reset();
        chk(abort_o === 1'b0 && prog_valid_o === 1'b0, "R1 reset state", {abort_o, prog_valid_o}, 0);
        wr(SEC_A, 16'h000F);
        wr(SEC_A, 16'h0029);
        chk(prog_valid_o === 1'b0 && abort_o === 1'b0, "R1 idle writes ignored", {abort_o, prog_valid_o}, 0);
    endtask

    task automatic t_full();
        clear_exp();
        wr(SEC_A, 16'h0025, 1'b1);
        wr(SEC_A, 16'd15);
        for (int i = 0; i < BW; i++) load(SEC_A + 22'h340 + AW'(i), 16'hC000 + DW'(i * 7));
        confirm_check("R2 R5 full", SEC_A, SEC_A + 22'h340);
    endtask

    task automatic t_short();
        clear_exp();
        wr(SEC_A + 22'h12, 16'h0025, 1'b1);
        wr(SEC_A + 22'h7F0, 16'd2);
        load(SEC_A + 22'h125, 16'h1111);
        load(SEC_A + 22'h123, 16'h2222);
        load(SEC_A + 22'h129, 16'h3333);
        confirm_check("R5 partial", SEC_A + 22'h4, SEC_A + 22'h120);
    endtask

    task automatic t_overwrite();
        clear_exp();
        wr(SEC_B, 16'h0025, 1'b1);
        wr(SEC_B, 16'd2);
        load(SEC_B + 22'h84, 16'hAAAA);
        load(SEC_B + 22'h84, 16'hBBBB);
        load(SEC_B + 22'h87, 16'hCCCC);
        chk(exp_w[4] == 16'hBBBB, "R7 expectation", exp_w[4], 16'hBBBB);
        confirm_check("R7 overwrite", SEC_B, SEC_B + 22'h80);
    endtask

    task automatic t_count_big();
        wr(SEC_A, 16'h0025, 1'b1);
        wr(SEC_A, 16'd16);
        chk(abort_o === 1'b1, "R3 count 16 aborts", abort_o, 1);
        wr(SEC_A, 16'h0025, 1'b1);
        wr(SEC_A, 16'd0);
        wr(SEC_A, 16'h0001);
        wr(SEC_A, 16'h0029);
        chk(abort_o === 1'b1 && prog_valid_o === 1'b0, "R10 start ignored", {abort_o, prog_valid_o}, 2);
        wr(22'h000555, 16'h00AA);
        wr(22'h0002AA, 16'h0055);
        wr(22'h000555, 16'h00F1);
        chk(abort_o === 1'b1, "R10 broken sequence keeps abort", abort_o, 1);
        wr(22'h000555, 16'h00AA);
        wr(22'h000555, 16'h00F0);
        chk(abort_o === 1'b1, "R10 skipped step keeps abort", abort_o, 1);
        clear_abort();
    endtask

    task automatic t_sector_bad();
        wr(SEC_A, 16'h0025, 1'b1);
        wr(SEC_B, 16'd3);
        chk(abort_o === 1'b1, "R4 count sector mismatch", abort_o, 1);
        clear_abort();
        wr(SEC_A, 16'h0025, 1'b1);
        wr(SEC_A, 16'd0);
        wr(SEC_A + 22'h10, 16'h5555);
        wr(SEC_B, 16'h0029);
        chk(abort_o === 1'b1 && prog_valid_o === 1'b0, "R4 confirm sector mismatch", abort_o, 1);
        clear_abort();
    endtask

    task automatic t_page_bad();
        wr(SEC_A, 16'h0025, 1'b1);
        wr(SEC_A, 16'd1);
        wr(SEC_A + 22'h200, 16'h1234);
        wr(SEC_A + 22'h210, 16'h5678);
        chk(abort_o === 1'b1, "R6 load outside page", abort_o, 1);
        clear_abort();
        wr(SEC_A, 16'h0025, 1'b1);
        wr(SEC_A, 16'd1);
        wr(SEC_B + 22'h200, 16'h1234);
        chk(abort_o === 1'b1, "R6 first load outside sector", abort_o, 1);
        clear_abort();
    endtask

    task automatic t_confirm_bad();
        wr(SEC_A, 16'h0025, 1'b1);
        wr(SEC_A, 16'd0);
        wr(SEC_A + 22'h31, 16'h9999);
        wr(SEC_A, 16'h0030);
        chk(abort_o === 1'b1 && prog_valid_o === 1'b0, "R9 wrong confirm code", abort_o, 1);
        clear_abort();
        clear_exp();
        wr(SEC_A, 16'h0025, 1'b1);
        wr(SEC_A, 16'd0);
        load(SEC_A + 22'h31, 16'h7777);
        confirm_check("R9 recovery then R8", SEC_A, SEC_A + 22'h30);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full();
        t_short();
        t_overwrite();
        t_count_big();
        t_sector_bad();
        t_page_bad();
        t_confirm_bad();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule